// File: doc/BRIEF.md
# Two-Channel Wiper Register Slave on a Two-Wire Serial Bus

This block is the digital front end of a two-channel, 256-step digital potentiometer. It listens to an I2C-style two-wire bus, with open-drain SDA and SCL sampled on a fast system clock. It answers to one 7-bit address, acknowledges the bytes it accepts and keeps two 8-bit wiper codes and a shutdown flag. The codes and the flag drive an analog ladder that lies outside this block. The only bus output is a pull-down enable for SDA.

A write has three bytes: the address, an instruction and the data. The instruction's top bit selects the channel and its next bit sets or clears shutdown. The data byte is loaded into the selected channel's wiper register. A write may end after the instruction byte. It then moves the channel pointer and updates the shutdown flag and leaves both wipers unchanged. A read has no channel field. It returns the wiper of the channel that the most recent write selected, and it repeats that byte for as long as the master acknowledges. Shutdown is only reported on an output. The wiper registers keep their contents, so leaving shutdown brings the stored positions back.

Top module: `dw_i2c_wiper`

## Requirements
- R1: After reset both wiper outputs equal 0x80, the shutdown output is 0, the SDA pull-down is off and the channel pointer selects channel 1 (pointer value 0).
- R2: The block answers only when the first seven bits after START, sent MSB first, equal 01011 followed by strap_i[1:0] (when USE_STRAP=1) or 0101111 (when USE_STRAP=0). For any other address it never pulls SDA and changes no register until the next START.
- R3: For an accepted byte (a matching address, the instruction byte, the data byte) the pull-down is on from the SCL fall that ends the 8th bit until the SCL fall that ends the 9th bit, and it is off during the eight bit periods.
- R4: The eighth bit after the address (R/W) is 0 for a write. In the instruction byte, bit 7 chooses the channel (0 selects channel 1 / wiper0_o, 1 selects channel 2 / wiper1_o). The following data byte is loaded into that channel and the other channel keeps its value.
- R5: Bit 6 of the instruction byte sets (1) or clears (0) shutdown_o and never alters a wiper code. Wipers written while shutdown is set take their new values, and clearing the bit leaves the stored codes on the outputs.
- R6: A write that ends with STOP after the instruction byte changes the channel pointer and the shutdown flag and leaves both wiper codes unchanged.
- R7: A read (R/W = 1) returns, MSB first and right after the address acknowledge, the wiper code of the channel that the last instruction byte selected.
- R8: If the master acknowledges a read byte, the same register is sent again. If it does not, the block releases SDA and ignores the bus until STOP or START.
- R9: The pull-down turns on only while the synchronized SCL is low, and a STOP turns it off.
- R10: A START at any point, a repeated START included, restarts address reception, so a write that sets the pointer can be followed at once by a read without an intervening STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Address strap levels, used as the two low address bits when USE_STRAP=1 |
| sda_pull_o | output | 1 | Drives SDA low when 1 (open-drain enable) |
| wiper0_o | output | WIPER_W | Wiper code of channel 1 |
| wiper1_o | output | WIPER_W | Wiper code of channel 2 |
| shutdown_o | output | 1 | Shutdown indication |

## Verification
The assertions check on every cycle that the pull-down turns on only while SCL is low and turns off after STOP. They also check that a wiper code moves only right after a data-byte load aimed at its own channel, and that a change of shutdown never moves a wiper in the same cycle. Some behaviour needs whole transactions and only the bench scenarios can show it: the address match over all 128 addresses in both address variants, write and readback over a sweep of codes on both channels, the pointer persisting across two-byte writes, repeated reads after master ACK, release after NACK, and a read that follows a repeated START.

// File: rtl/dw_pkg.sv
package dw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_INSTR,
    ST_IACK,
    ST_DATA,
    ST_DACK,
    ST_RD,
    ST_RACK,
    ST_RNEXT,
    ST_WAIT
  } dw_state_e;

  // Full 7-bit device address from the fixed high part and the selected low part.
  function automatic logic [6:0] dev_addr(input logic [4:0] hi,
                                          input logic [1:0] lo_fixed,
                                          input logic [1:0] strap,
                                          input logic       use_strap);
    return {hi, (use_strap ? strap : lo_fixed)};
  endfunction

  // Serial shift, MSB first.
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b);
    return {sh[6:0], b};
  endfunction

endpackage

// File: rtl/dw_sync.sv
module dw_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dw_bus_events.sv
module dw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_evt = scl_s && scl_q && sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
endmodule

// File: rtl/dw_wiper_bank.sv
module dw_wiper_bank #(
  parameter int WIPER_W = 8,
  parameter int NCH     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [$clog2(NCH)-1:0]          sel,
  input  logic [WIPER_W-1:0]              data,
  output logic [NCH-1:0][WIPER_W-1:0]     codes
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W-1);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) codes[c] <= MID;
        else if (load && (sel == c)) codes[c] <= data;
      end
    end
  endgenerate
endmodule

// File: rtl/dw_i2c_wiper.sv
module dw_i2c_wiper #(
  parameter int         WIPER_W       = 8,
  parameter bit         USE_STRAP     = 1'b1,
  parameter logic [4:0] ADDR_HI       = 5'b01011,
  parameter logic [1:0] ADDR_LO_FIXED = 2'b11,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               shutdown_o
);
  import dw_pkg::*;

  localparam int NCH    = 2;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W-1);

  // Named internal events, observed by the checker.
  logic       scl_s, sda_s;
  logic       start_evt, stop_evt, scl_rise, scl_fall;
  logic       load_evt;
  logic       ptr_q;

  logic [1:0] pins_s;
  dw_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  dw_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  dw_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh, tx;
  logic             rw_q, sd_q, slot_q, pull_q;

  logic             byte_end;
  logic [7:0]       rx_byte;
  logic [7:0]       rd_byte;
  logic [NCH-1:0][WIPER_W-1:0] codes;

  assign byte_end = scl_rise && (cnt == LAST_BIT);
  assign rx_byte  = shift_in(sh, sda_s);
  assign load_evt = (state == ST_DATA) && byte_end;
  assign rd_byte  = BYTE_W'(codes[ptr_q]);

  dw_wiper_bank #(.WIPER_W(WIPER_W), .NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .sel(ptr_q),
    .data(rx_byte[WIPER_W-1:0]), .codes(codes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw_q   <= 1'b0;
      sd_q   <= 1'b0;
      ptr_q  <= 1'b0;
      slot_q <= 1'b0;
      pull_q <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      slot_q <= 1'b0;
      pull_q <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      slot_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
          end
          if (byte_end) begin
            if (state == ST_ADDR) begin
              if (rx_byte[7:1] == dev_addr(ADDR_HI, ADDR_LO_FIXED, strap_i, USE_STRAP)) begin
                rw_q  <= rx_byte[0];
                state <= ST_AACK;
              end else begin
                state <= ST_WAIT;
              end
            end else if (state == ST_INSTR) begin
              ptr_q <= rx_byte[7];
              sd_q  <= rx_byte[6];
              state <= ST_IACK;
            end else begin
              state <= ST_DACK;
            end
          end
        end
        ST_AACK, ST_IACK, ST_DACK: begin
          if (scl_fall) begin
            if (!slot_q) begin
              pull_q <= 1'b1;
              slot_q <= 1'b1;
            end else begin
              slot_q <= 1'b0;
              cnt    <= '0;
              if (state == ST_AACK && rw_q) begin
                tx     <= rd_byte;
                pull_q <= ~rd_byte[7];
                state  <= ST_RD;
              end else begin
                pull_q <= 1'b0;
                state  <= (state == ST_AACK) ? ST_INSTR :
                          (state == ST_IACK) ? ST_DATA : ST_WAIT;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              pull_q <= 1'b0;
              state  <= ST_RACK;
            end else begin
              cnt    <= cnt + 1'b1;
              tx     <= tx << 1;
              pull_q <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) state <= sda_s ? ST_WAIT : ST_RNEXT;
        end
        ST_RNEXT: begin
          if (scl_fall) begin
            cnt    <= '0;
            tx     <= rd_byte;
            pull_q <= ~rd_byte[7];
            state  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
  assign wiper0_o   = codes[0];
  assign wiper1_o   = codes[1];
  assign shutdown_o = sd_q;
endmodule

// File: rtl/dw_i2c_wiper_chk.sv
module dw_i2c_wiper_chk #(
  parameter int WIPER_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               stop_evt,
  input logic               load_evt,
  input logic               ptr_q,
  input logic               sda_pull_o,
  input logic [WIPER_W-1:0] wiper0_o,
  input logic [WIPER_W-1:0] wiper1_o,
  input logic               shutdown_o
);
  // R9
  pull_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);

  // R4
  wiper0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wiper0_o) |-> ($past(load_evt) && !$past(ptr_q)));

  // R4
  wiper1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wiper1_o) |-> ($past(load_evt) && $past(ptr_q)));

  // R5
  sd_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(shutdown_o) |-> ($stable(wiper0_o) && $stable(wiper1_o)));
endmodule

bind dw_i2c_wiper dw_i2c_wiper_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
  .load_evt(load_evt), .ptr_q(ptr_q), .sda_pull_o(sda_pull_o),
  .wiper0_o(wiper0_o), .wiper1_o(wiper1_o), .shutdown_o(shutdown_o)
);

// File: tb/test_dw_i2c_wiper.sv
`timescale 1ns/1ps
module test_dw_i2c_wiper;
  localparam int Q = 8;  // system clocks per quarter bus bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic pull_a, pull_b, sd_a, sd_b;
  logic [7:0] wa0, wa1, wb0, wb1;
  wire sda_line = sda_m & ~pull_a & ~pull_b;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_w [2];

  always #2 clk = ~clk;  // 250 MHz

  // Strap variant answers at 0101110, fixed variant at 0101111.
  dw_i2c_wiper #(.USE_STRAP(1'b1)) i_dw_i2c_wiper (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(2'b10),
    .sda_pull_o(pull_a), .wiper0_o(wa0), .wiper1_o(wa1), .shutdown_o(sd_a));

  dw_i2c_wiper #(.USE_STRAP(1'b0)) i_dw_i2c_wiper_fix (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(2'b00),
    .sda_pull_o(pull_b), .wiper0_o(wb0), .wiper1_o(wb1), .shutdown_o(sd_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tq; scl_m = 1'b1; tq; sda_m = 1'b0; tq; scl_m = 1'b0; tq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tq; scl_m = 1'b1; tq; sda_m = 1'b1; tq; tq;
  endtask

  task automatic send_bit(input logic b, output logic p);
    sda_m = b; tq; scl_m = 1'b1; tq; p = pull_a | pull_b; tq; scl_m = 1'b0; tq;
  endtask

  task automatic recv_bit(output logic b, output logic pa, output logic pb);
    sda_m = 1'b1; tq; scl_m = 1'b1; tq;
    b = sda_line; pa = pull_a; pb = pull_b;
    tq; scl_m = 1'b0; tq;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic aa, output logic ab,
                           output logic early);
    logic p, d;
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i], p);
      early |= p;
    end
    recv_bit(d, aa, ab);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] v);
    logic pa, pb, p;
    for (int i = 7; i >= 0; i--) recv_bit(v[i], pa, pb);
    send_bit(~mack, p);
  endtask

  task automatic wr(input logic [6:0] a, input logic ch, input logic sd,
                    input logic [7:0] v, input bit with_data,
                    output logic [2:0] aa, output logic [2:0] ab);
    logic e;
    aa = '0; ab = '0;
    bus_start;
    send_byte({a, 1'b0}, aa[0], ab[0], e);
    send_byte({ch, sd, 6'b0}, aa[1], ab[1], e);
    if (with_data) send_byte(v, aa[2], ab[2], e);
    bus_stop;
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] v, output logic ack);
    logic ab, e;
    bus_start;
    send_byte({a, 1'b1}, ack, ab, e);
    get_byte(1'b0, v);
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic aa, ab, early, ack;
    logic [2:0] acks_a, acks_b;
    logic [7:0] v;
    logic pa, pb, d;

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    tq;
    // R1 reset state
    chk(wa0 == 8'h80, "R1 wiper0", wa0, 8'h80);
    chk(wa1 == 8'h80, "R1 wiper1", wa1, 8'h80);
    chk(sd_a == 1'b0, "R1 shutdown", sd_a, 0);
    chk(pull_a == 1'b0 && pull_b == 1'b0, "R1 pull", pull_a | pull_b, 0);
    chk(wb0 == 8'h80 && wb1 == 8'h80, "R1 fixed wipers", wb0, 8'h80);
    exp_w[0] = 8'h80; exp_w[1] = 8'h80;

    // R2 address sweep over all 128 addresses, both variants
    for (int a = 0; a < 128; a++) begin
      bus_start;
      send_byte({7'(a), 1'b0}, aa, ab, early);
      bus_stop;
      chk(aa == (a == 46), "R2 strap variant ack", aa, (a == 46));
      chk(ab == (a == 47), "R2 fixed variant ack", ab, (a == 47));
      if (a == 46) chk(early == 1'b0, "R3 no pull during bits", early, 0);
      chk(pull_a == 1'b0, "R9 released after stop", pull_a, 0);
    end

    // R2 full writes to near-miss addresses leave registers alone
    for (int k = 1; k < 7; k++) begin
      wr(7'h2E ^ 7'(1 << k), 1'b0, 1'b1, 8'h00, 1'b1, acks_a, acks_b);
      chk(acks_a == 3'b000, "R2 no ack on mismatch", acks_a, 0);
      chk(wa0 == 8'h80 && sd_a == 1'b0, "R2 mismatch no effect", wa0, 8'h80);
    end

    // R3 R4 R7 write/readback sweep on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int x = 0; x < 256; x += 17) begin
        wr(7'h2E, ch[0], 1'b0, 8'(x), 1'b1, acks_a, acks_b);
        chk(acks_a == 3'b111, "R3 three acks", acks_a, 3'b111);
        exp_w[ch] = 8'(x);
        chk(wa0 == exp_w[0], "R4 wiper0", wa0, exp_w[0]);
        chk(wa1 == exp_w[1], "R4 wiper1", wa1, exp_w[1]);
        rd1(7'h2E, v, ack);
        chk(ack == 1'b1 && v == exp_w[ch], "R7 readback", v, exp_w[ch]);
      end
    end

    // R2 fixed variant accepts its own write, strap variant untouched
    wr(7'h2F, 1'b1, 1'b0, 8'h3C, 1'b1, acks_a, acks_b);
    chk(acks_b == 3'b111 && wb1 == 8'h3C, "R2 fixed variant write", wb1, 8'h3C);
    chk(wa1 == exp_w[1], "R2 other device unchanged", wa1, exp_w[1]);

    // R5 shutdown keeps codes, writes during shutdown, restore
    wr(7'h2E, 1'b0, 1'b1, 8'h5A, 1'b1, acks_a, acks_b);
    chk(sd_a == 1'b1, "R5 shutdown set", sd_a, 1);
    chk(wa0 == 8'h5A && wa1 == 8'hFF, "R5 codes kept", wa0, 8'h5A);
    wr(7'h2E, 1'b1, 1'b1, 8'h00, 1'b1, acks_a, acks_b);
    chk(wa1 == 8'h00 && sd_a == 1'b1, "R5 write while shutdown", wa1, 8'h00);
    wr(7'h2E, 1'b1, 1'b1, 8'h81, 1'b1, acks_a, acks_b);
    wr(7'h2E, 1'b0, 1'b0, 8'h00, 1'b0, acks_a, acks_b);
    chk(sd_a == 1'b0, "R5 shutdown cleared", sd_a, 0);
    chk(wa0 == 8'h5A && wa1 == 8'h81, "R5 stored codes restored", wa1, 8'h81);

    // R6 two-byte write moves pointer only
    chk(acks_a == 3'b011, "R6 two acks", acks_a, 3'b011);
    rd1(7'h2E, v, ack);
    chk(v == 8'h5A, "R6 pointer to channel 1", v, 8'h5A);
    wr(7'h2E, 1'b1, 1'b0, 8'h00, 1'b0, acks_a, acks_b);
    chk(wa0 == 8'h5A && wa1 == 8'h81, "R6 wipers unchanged", wa0, 8'h5A);
    rd1(7'h2E, v, ack);
    chk(v == 8'h81, "R6 pointer to channel 2", v, 8'h81);

    // R8 master ack repeats the register, nack releases
    bus_start;
    send_byte({7'h2E, 1'b1}, aa, ab, early);
    for (int n = 0; n < 3; n++) begin
      get_byte(n < 2, v);
      chk(v == 8'h81, "R8 repeated byte", v, 8'h81);
    end
    recv_bit(d, pa, pb);
    chk(pa == 1'b0 && d == 1'b1, "R8 released after nack", pa, 0);
    bus_stop;

    // R10 repeated START: pointer write then read without STOP
    bus_start;
    send_byte({7'h2E, 1'b0}, aa, ab, early);
    send_byte(8'h00, aa, ab, early);
    bus_start;
    send_byte({7'h2E, 1'b1}, aa, ab, early);
    chk(aa == 1'b1, "R10 address ack after restart", aa, 1);
    get_byte(1'b0, v);
    bus_stop;
    chk(v == 8'h5A, "R10 read after repeated start", v, 8'h5A);
    chk(pull_a == 1'b0, "R9 idle after stop", pull_a, 0);

    // R1 reset in mid-run restores midscale and normal mode
    wr(7'h2E, 1'b0, 1'b1, 8'h07, 1'b1, acks_a, acks_b);
    #1 rst_n = 1'b0;
    tq;
    rst_n = 1'b1;
    tq;
    chk(wa0 == 8'h80 && wa1 == 8'h80, "R1 midscale after reset", wa0, 8'h80);
    chk(sd_a == 1'b0, "R1 shutdown cleared by reset", sd_a, 0);
    rd1(7'h2E, v, ack);
    chk(v == 8'h80, "R1 read after reset", v, 8'h80);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule